// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a programmed mode word into the sequence of column addresses that a memory controller presents during one read or write burst. The mode word is captured on a load strobe and decoded into four fields: a burst length, an ordering type, a CAS latency and an error indication. A start strobe carries the first column of a burst. From the next cycle the block walks through the burst one beat per enabled clock. It reports the current column, a valid flag and a last-beat flag.

Two orderings are supported. Sequential order counts upward and wraps inside the block aligned to the burst length. Interleaved order XORs the start offset with the beat number. A full-page setting walks every column of the row, wrapping at the top, until a stop or a new start ends it. A clock-enable input stalls the whole sequence. The decoded CAS latency is passed on for the data-path logic downstream.

The control is a three-state machine:
- ST_IDLE: no burst.
- ST_BURST: fixed-length burst.
- ST_PAGE: full-page burst.

Its transitions are named below:
- T_START: ST_IDLE to ST_BURST or ST_PAGE, chosen by the latched length.
- T_RESTART: from ST_BURST or ST_PAGE back to ST_BURST or ST_PAGE on a new start.
- T_DONE: ST_BURST to ST_IDLE after the final beat.
- T_STOP: ST_BURST or ST_PAGE to ST_IDLE on stop.
- T_HOLD: any state to itself while the clock enable is low.

Top module: `sdram_burst_colgen`

## Requirements
- R1: `mode_word` is stored on a cycle with `mode_load` high. `cas_lat` then reads 1, 2 or 3 for bits [6:4] equal to 001, 010 or 011, and reads 0 for any other code.
- R2: `mode_err` is high in three cases: length bits [2:0] are 100, 101 or 110; length bits are 111 together with bit 3 = 1; or the latency code is reserved. A burst started under an erroneous length code is a single beat.
- R3: When `start` is high with `clk_en` high, `col_valid` is 1 on the next cycle and `col_out` equals `start_col`. A start aborts any burst in progress and begins a new one.
- R4: With bit 3 = 0 and length code 000/001/010/011 (1/2/4/8 beats), beat k has two parts. Its upper bits are those of the start column. Its low log2(length) bits are the start's low bits plus k, modulo the length.
- R5: With bit 3 = 1, beat k keeps the upper bits of the start column, and its low log2(length) bits are the start's low bits XOR k.
- R6: With length code 111 and bit 3 = 0, the column increments on every enabled cycle and wraps from 255 to 0. This continues until a stop or a start arrives, and `col_last` never rises.
- R7: On a fixed-length burst, `col_last` is high only on the final beat. After that beat has been clocked with `clk_en` high, `col_valid` falls.
- R8: `stop` with `clk_en` high and no `start` makes `col_valid` low on the next cycle. When `start` and `stop` arrive together, the start wins.
- R9: While `clk_en` is low, `col_out`, `col_valid` and `col_last` hold their values, and `start` and `stop` are ignored.
- R10: A burst keeps the length and ordering that were in force at its start, even if a new mode word is loaded while it runs.
- R11: After reset, `col_valid` and `col_last` are 0, `cas_lat` is 2 and `mode_err` is 0. The reset mode is latency 2, sequential, one beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_load | input | 1 | Capture `mode_word` this cycle |
| mode_word | input | 7 | Latency [6:4], ordering [3], length [2:0] |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | COL_W | First column of the burst |
| stop | input | 1 | Terminate the burst |
| clk_en | input | 1 | Advance enable; low stalls the sequence |
| col_out | output | COL_W | Current column |
| col_valid | output | 1 | A burst beat is being presented |
| col_last | output | 1 | Final beat of a fixed-length burst |
| cas_lat | output | 2 | Decoded CAS latency, 0 if reserved |
| mode_err | output | 1 | Reserved or illegal mode combination |

## Verification
The bench aims at the wrap points, because a generator that wraps wrongly still produces plausible addresses.
- A sequential burst starting mid-block must return to the block base. A design that carries into the upper bits would step into the next block.
- An interleaved burst from an odd start must produce the XOR order and not a rotation of the sequential one.
- A full-page burst must cross from 255 to 0 with no last flag. A design that treats it as a fixed length would stop or raise last.

Stall cycles with stray start and stop pulses check that the column freezes. A mode reload in mid-burst checks that the running burst keeps its latched settings. A simultaneous start and stop checks that the start wins. Illegal length codes must collapse to a single beat with the error flag set.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    localparam int MODE_W = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } colgen_state_e;

    typedef struct packed {
        logic [1:0] len_exp;     // log2 of fixed burst length
        logic       interleave;
        logic       full_page;
        logic       err;
        logic [1:0] cas_lat;
    } colgen_mode_t;

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
    import colgen_pkg::*;
#(
    parameter logic [MODE_W-1:0] RESET_MODE = 7'b010_0_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output colgen_mode_t      mode
);

    logic [MODE_W-1:0] mode_q;
    logic              len_bad;
    logic              cas_bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= RESET_MODE;
        end else if (load) begin
            mode_q <= word;
        end
    end

    always_comb begin
        mode.len_exp    = 2'd0;
        mode.full_page  = 1'b0;
        mode.interleave = mode_q[3];
        len_bad         = 1'b0;
        unique case (mode_q[2:0])
            3'b000: mode.len_exp = 2'd0;
            3'b001: mode.len_exp = 2'd1;
            3'b010: mode.len_exp = 2'd2;
            3'b011: mode.len_exp = 2'd3;
            3'b111: begin
                if (mode_q[3]) begin
                    len_bad = 1'b1;
                end else begin
                    mode.full_page = 1'b1;
                end
            end
            default: len_bad = 1'b1;
        endcase

        cas_bad = 1'b0;
        unique case (mode_q[6:4])
            3'b001:  mode.cas_lat = 2'd1;
            3'b010:  mode.cas_lat = 2'd2;
            3'b011:  mode.cas_lat = 2'd3;
            default: begin
                mode.cas_lat = 2'd0;
                cas_bad      = 1'b1;
            end
        endcase

        mode.err = len_bad | cas_bad;
    end

endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] start_col,
    input  colgen_mode_t     mode,
    output logic [COL_W-1:0] base,
    output logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] mask,
    output logic             inter,
    output logic             valid,
    output logic             last
);

    localparam logic [COL_W-1:0] ONE   = {{(COL_W-1){1'b0}}, 1'b1};
    localparam logic [COL_W-1:0] ALL_1 = {COL_W{1'b1}};

    colgen_state_e    state_q, state_d;
    logic [COL_W-1:0] new_mask;
    logic             go;
    logic             at_end;

    assign go       = clk_en & start;
    assign new_mask = mode.full_page ? ALL_1 : ((ONE << mode.len_exp) - ONE);
    assign at_end   = (beat == mask);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (clk_en) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) state_d = mode.full_page ? ST_PAGE : ST_BURST;  // T_START
                end
                ST_BURST: begin
                    if (start)       state_d = mode.full_page ? ST_PAGE : ST_BURST; // T_RESTART
                    else if (stop)   state_d = ST_IDLE;                             // T_STOP
                    else if (at_end) state_d = ST_IDLE;                             // T_DONE
                end
                ST_PAGE: begin
                    if (start)     state_d = mode.full_page ? ST_PAGE : ST_BURST;   // T_RESTART
                    else if (stop) state_d = ST_IDLE;                               // T_STOP
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // burst context and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base  <= '0;
            beat  <= '0;
            mask  <= '0;
            inter <= 1'b0;
        end else if (go) begin
            base  <= start_col;
            beat  <= '0;
            mask  <= new_mask;
            inter <= mode.interleave;
        end else if (clk_en && (state_q != ST_IDLE)) begin
            beat <= beat + ONE;
        end
    end

    // outputs
    always_comb begin
        valid = 1'b0;
        last  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_BURST: begin
                valid = 1'b1;
                last  = at_end;
            end
            ST_PAGE:  valid = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/colgen_addr.sv
module colgen_addr #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             inter,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] seq_off;
    logic [COL_W-1:0] xor_off;

    assign seq_off = base + beat;
    assign xor_off = base ^ beat;
    assign col     = (base & ~mask) | ((inter ? xor_off : seq_off) & mask);

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int                COL_W      = 8,
    parameter logic [MODE_W-1:0] RESET_MODE = 7'b010_0_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              stop,
    input  logic              clk_en,
    output logic [COL_W-1:0]  col_out,
    output logic              col_valid,
    output logic              col_last,
    output logic [1:0]        cas_lat,
    output logic              mode_err
);

    colgen_mode_t     mode;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] mask;
    logic             inter;

    colgen_mode_dec #(.RESET_MODE(RESET_MODE)) u_dec (
        .clk  (clk),
        .rst_n(rst_n),
        .load (mode_load),
        .word (mode_word),
        .mode (mode)
    );

    colgen_seq #(.COL_W(COL_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .start    (start),
        .stop     (stop),
        .start_col(start_col),
        .mode     (mode),
        .base     (base),
        .beat     (beat),
        .mask     (mask),
        .inter    (inter),
        .valid    (col_valid),
        .last     (col_last)
    );

    colgen_addr #(.COL_W(COL_W)) u_addr (
        .base (base),
        .beat (beat),
        .mask (mask),
        .inter(inter),
        .col  (col_out)
    );

    assign cas_lat  = mode.cas_lat;
    assign mode_err = mode.err;

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_load,
    input logic [MODE_W-1:0] mode_word,
    input logic              start,
    input logic [COL_W-1:0]  start_col,
    input logic              stop,
    input logic              clk_en,
    input logic [COL_W-1:0]  col_out,
    input logic              col_valid,
    input logic              col_last,
    input logic [1:0]        cas_lat,
    input logic              mode_err
);

    AST_START_LOADS_COL: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && start |=> col_valid && (col_out == $past(start_col))); // R3

    AST_LAST_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid); // R7

    AST_LAST_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && col_last && !start |=> !col_valid); // R7

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && stop && !start |=> !col_valid); // R8

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(col_out) && $stable(col_valid) && $stable(col_last)); // R9

    AST_RSVD_LEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        mode_load && mode_word[2] && (mode_word[1:0] != 2'b11) |=> mode_err); // R2

    AST_CAS3_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_load && (mode_word[6:4] == 3'b011) |=> cas_lat == 2'd3); // R1

    AST_RSVD_CAS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_lat == 2'd0) |-> mode_err); // R2

endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sdram_burst_colgen_bench.sv
module sdram_burst_colgen_bench;

    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_load = 1'b0;
    logic [6:0]       mode_word = '0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             stop = 1'b0;
    logic             clk_en = 1'b1;
    logic [COL_W-1:0] col_out;
    logic             col_valid;
    logic             col_last;
    logic [1:0]       cas_lat;
    logic             mode_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    sdram_burst_colgen #(.COL_W(COL_W)) u_sdram_burst_colgen (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .start(start), .start_col(start_col), .stop(stop), .clk_en(clk_en),
        .col_out(col_out), .col_valid(col_valid), .col_last(col_last),
        .cas_lat(cas_lat), .mode_err(mode_err)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_col(input int b, input int k, input int len, input bit il);
        int m = len - 1;
        int off = il ? ((b ^ k) & m) : ((b + k) & m);
        return (b & ~m & 255) | off;
    endfunction

    task automatic load(input logic [6:0] w);
        mode_load = 1'b1;
        mode_word = w;
        cyc();
        mode_load = 1'b0;
    endtask

    task automatic burst(input string tag, input int b, input int len, input bit il);
        start = 1'b1;
        start_col = COL_W'(b);
        cyc();
        start = 1'b0;
        for (int k = 0; k < len; k++) begin
            chk({tag, " valid"}, int'(col_valid), 1);
            chk({tag, " col"}, int'(col_out), exp_col(b, k, len, il));
            chk({tag, " last"}, int'(col_last), (k == len - 1) ? 1 : 0);
            cyc();
        end
        chk({tag, " end"}, int'(col_valid), 0);
    endtask

    task automatic t_reset();
        chk("R11 valid", int'(col_valid), 0);
        chk("R11 last", int'(col_last), 0);
        chk("R11 cas", int'(cas_lat), 2);
        chk("R11 err", int'(mode_err), 0);
    endtask

    task automatic t_cas();
        load(7'b001_0_000); chk("R1 cas1", int'(cas_lat), 1); chk("R1 err", int'(mode_err), 0);
        load(7'b011_0_000); chk("R1 cas3", int'(cas_lat), 3);
        load(7'b101_0_010); chk("R2 cas rsvd", int'(cas_lat), 0); chk("R2 cas err", int'(mode_err), 1);
    endtask

    task automatic t_seq();
        load(7'b010_0_010); burst("R4 len4 s1", 1, 4, 0);
        load(7'b010_0_011); burst("R4 len8 s13", 13, 8, 0);
        load(7'b010_0_001); burst("R4 len2 s7", 7, 2, 0);
        load(7'b010_0_000); burst("R7 len1 s9", 9, 1, 0);
    endtask

    task automatic t_inter();
        int ref8[8] = '{5, 4, 7, 6, 1, 0, 3, 2};
        load(7'b010_1_011);
        start = 1'b1; start_col = 8'd5; cyc(); start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            chk("R5 il8 col", int'(col_out), ref8[k]);
            cyc();
        end
        chk("R7 il8 end", int'(col_valid), 0);
        load(7'b010_1_010); burst("R5 il4 s14", 14, 4, 1);
    endtask

    task automatic t_err();
        load(7'b010_0_101); chk("R2 len rsvd err", int'(mode_err), 1);
        burst("R2 rsvd len1", 13, 1, 0);
        load(7'b010_1_111); chk("R2 page il err", int'(mode_err), 1);
        burst("R2 page il len1", 200, 1, 0);
    endtask

    task automatic t_page();
        load(7'b010_0_111); chk("R6 err", int'(mode_err), 0);
        start = 1'b1; start_col = 8'd250; cyc(); start = 1'b0;
        for (int k = 0; k < 10; k++) begin
            chk("R6 page col", int'(col_out), (250 + k) % 256);
            chk("R6 page last", int'(col_last), 0);
            chk("R6 page valid", int'(col_valid), 1);
            cyc();
        end
        stop = 1'b1; cyc(); stop = 1'b0;
        chk("R8 page stop", int'(col_valid), 0);
    endtask

    task automatic t_restart();
        load(7'b010_0_011);
        start = 1'b1; start_col = 8'd0; cyc(); start = 1'b0;
        cyc(); cyc();
        chk("R3 pre", int'(col_out), 2);
        start = 1'b1; start_col = 8'd20; cyc(); start = 1'b0;
        chk("R3 restart col", int'(col_out), 20);
        cyc(); chk("R3 next", int'(col_out), 21);
        start = 1'b1; stop = 1'b1; start_col = 8'd3; cyc(); start = 1'b0; stop = 1'b0;
        chk("R8 start wins valid", int'(col_valid), 1);
        chk("R8 start wins col", int'(col_out), 3);
        cyc(); stop = 1'b1; cyc(); stop = 1'b0;
        chk("R8 fixed stop", int'(col_valid), 0);
    endtask

    task automatic t_stall();
        load(7'b010_0_010);
        start = 1'b1; start_col = 8'd8; cyc(); start = 1'b0;
        cyc(); chk("R9 pre", int'(col_out), 9);
        clk_en = 1'b0; start = 1'b1; stop = 1'b1; start_col = 8'd40;
        for (int k = 0; k < 3; k++) begin
            cyc();
            chk("R9 hold col", int'(col_out), 9);
            chk("R9 hold valid", int'(col_valid), 1);
            chk("R9 hold last", int'(col_last), 0);
        end
        clk_en = 1'b1; start = 1'b0; stop = 1'b0;
        cyc(); chk("R9 resume", int'(col_out), 10);
        cyc(); chk("R9 resume last col", int'(col_out), 11); chk("R7 last", int'(col_last), 1);
        cyc(); chk("R7 done", int'(col_valid), 0);
    endtask

    task automatic t_latch();
        load(7'b010_0_010);
        start = 1'b1; start_col = 8'd4; cyc(); start = 1'b0;
        chk("R10 b0", int'(col_out), 4);
        mode_load = 1'b1; mode_word = 7'b010_1_011; cyc(); mode_load = 1'b0;
        chk("R10 b1", int'(col_out), 5);
        cyc(); chk("R10 b2", int'(col_out), 6);
        cyc(); chk("R10 b3", int'(col_out), 7); chk("R10 last", int'(col_last), 1);
        cyc(); chk("R10 end", int'(col_valid), 0);
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(); cyc();
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_cas();
        t_seq();
        t_inter();
        t_err();
        t_page();
        t_restart();
        t_stall();
        t_latch();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule